// File: doc/BRIEF.md
# Control Register Read-Modify-Write Unit

This block carries out the six atomic control-register instructions of a RISC-V style core: swap, bit-set and bit-clear, each in a register form and an immediate form. It holds a small bank of storage registers that sit at consecutive 12-bit addresses. When an operation is presented, the block returns the register's current contents for the destination register in the same cycle. It applies the update to the bank on the next rising clock edge.

Each operation carries the source operand value and one 5-bit field. For the register forms that field is the source register index. For the immediate forms it is the immediate itself. The same field decides whether the write happens. The destination index decides whether the swap forms perform their read. Addresses outside the bank read as zero and cannot be written. Privilege checks and counters are not part of the block.

Top module: `csr_rmw_unit`

## Requirements
- R1: A synchronous active-high `rst` clears every bank register to zero.
- R2: Operation code 3'b001 (register swap) writes `src_value` into the addressed register. When `dst_index` is nonzero it raises `dst_write` and returns the old value on `dst_value`.
- R3: For either swap form (3'b001, 3'b101) with `dst_index` equal to 0, `dst_write` is 0 and `dst_value` is 0. The write still takes place.
- R4: Operation code 3'b101 (immediate swap) writes `op_field` zero-extended to XLEN bits and ignores `src_value`.
- R5: Operation code 3'b010 ORs `src_value` into the register. Operation code 3'b011 clears the register bits that are set in `src_value`.
- R6: For codes 3'b010 and 3'b011 with `op_field` equal to 0, the register is left unchanged. The read is still performed, so `dst_write` is 1 and `dst_value` carries the register contents.
- R7: Codes 3'b110 (immediate set) and 3'b111 (immediate clear) use `op_field`, zero-extended, as the mask. When `op_field` is 0 they leave the register unchanged but still read it.
- R8: `dst_value` is the register contents from before the write. It follows `csr_addr` combinationally within the cycle.
- R9: An address outside the bank returns 0 on `dst_value` and is never written. `dst_write` still follows the read rules.
- R10: With `op_valid` low, or with the reserved codes 3'b000 and 3'b100, `dst_write` is 0, `dst_value` is 0 and no register changes.
- R11: Bank register k answers at address BASE_ADDR+k, for k from 0 to NUM_REGS-1. The defaults are 12'h7C0 and 4 registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; bank updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation selector (see R2-R7, R10) |
| csr_addr | input | 12 | Register address |
| src_value | input | XLEN | Source register value for the register forms |
| op_field | input | 5 | Source register index or 5-bit immediate |
| dst_index | input | 5 | Destination register index |
| dst_value | output | XLEN | Pre-write register value for the destination |
| dst_write | output | 1 | Destination register is to be written |

## Verification
The case hardest to reach from the ports is a set or clear whose write is suppressed, either by a zero source index or by a zero immediate. Such an operation still reads the register and still raises `dst_write`, so its effect on the bank cannot be seen in the same cycle. The stimulus table therefore puts each suppressed case with a large all-ones mask directly before a later operation that reads the same register. The checks on that later read show whether anything leaked into storage. Unmapped addresses on both sides of the bank, the reserved codes and idle cycles are handled the same way, each followed by a read-back.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

    typedef enum logic [2:0] {
        OPC_RSVD0 = 3'b000,
        OPC_SWAP  = 3'b001,
        OPC_SET   = 3'b010,
        OPC_CLR   = 3'b011,
        OPC_RSVD4 = 3'b100,
        OPC_SWAPI = 3'b101,
        OPC_SETI  = 3'b110,
        OPC_CLRI  = 3'b111
    } opc_e;

    typedef enum logic [1:0] {
        MRG_NONE = 2'd0,
        MRG_SWAP = 2'd1,
        MRG_SET  = 2'd2,
        MRG_CLR  = 2'd3
    } merge_e;

    typedef struct packed {
        merge_e kind;
        logic   use_imm;
        logic   rd_en;
        logic   wr_en;
    } ctl_t;

    localparam int ADDR_W  = 12;
    localparam int FIELD_W = 5;

    function automatic logic addr_hit(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] base,
                                      input int unsigned       count);
        logic [ADDR_W-1:0] off;
        off = addr - base;
        return (addr >= base) && (32'(off) < count);
    endfunction

endpackage

// File: rtl/csr_rmw_decode.sv
module csr_rmw_decode
    import csr_rmw_pkg::*;
(
    input  logic               valid,
    input  logic [2:0]         code,
    input  logic [FIELD_W-1:0] field,
    input  logic [FIELD_W-1:0] dst,
    output ctl_t               ctl
);
    logic field_nz;
    logic dst_nz;

    assign field_nz = |field;
    assign dst_nz   = |dst;

    always_comb begin
        ctl = '{kind: MRG_NONE, use_imm: 1'b0, rd_en: 1'b0, wr_en: 1'b0};
        if (valid) begin
            unique case (opc_e'(code))
                OPC_SWAP:  ctl = '{kind: MRG_SWAP, use_imm: 1'b0, rd_en: dst_nz, wr_en: 1'b1};
                OPC_SWAPI: ctl = '{kind: MRG_SWAP, use_imm: 1'b1, rd_en: dst_nz, wr_en: 1'b1};
                OPC_SET:   ctl = '{kind: MRG_SET,  use_imm: 1'b0, rd_en: 1'b1, wr_en: field_nz};
                OPC_SETI:  ctl = '{kind: MRG_SET,  use_imm: 1'b1, rd_en: 1'b1, wr_en: field_nz};
                OPC_CLR:   ctl = '{kind: MRG_CLR,  use_imm: 1'b0, rd_en: 1'b1, wr_en: field_nz};
                OPC_CLRI:  ctl = '{kind: MRG_CLR,  use_imm: 1'b1, rd_en: 1'b1, wr_en: field_nz};
                default:   ctl = '{kind: MRG_NONE, use_imm: 1'b0, rd_en: 1'b0, wr_en: 1'b0};
            endcase
        end
    end
endmodule

// File: rtl/csr_rmw_merge.sv
module csr_rmw_merge
    import csr_rmw_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  ctl_t               ctl,
    input  logic [XLEN-1:0]    old_val,
    input  logic [XLEN-1:0]    src_val,
    input  logic [FIELD_W-1:0] imm,
    output logic [XLEN-1:0]    new_val
);
    logic [XLEN-1:0] mask;

    assign mask = ctl.use_imm ? {{(XLEN-FIELD_W){1'b0}}, imm} : src_val;

    always_comb begin
        unique case (ctl.kind)
            MRG_SWAP: new_val = mask;
            MRG_SET:  new_val = old_val | mask;
            MRG_CLR:  new_val = old_val & ~mask;
            default:  new_val = old_val;
        endcase
    end
endmodule

// File: rtl/csr_rmw_bank.sv
module csr_rmw_bank
    import csr_rmw_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     hit,
    input  logic [IDX_W-1:0]         idx,
    input  logic                     wr,
    input  logic [XLEN-1:0]          wdata,
    output logic [XLEN-1:0]          rdata,
    output logic [NUM_REGS*XLEN-1:0] flat
);
    logic [XLEN-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic sel;
        assign sel = wr && hit && (32'(idx) == g);
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (sel) begin
                regs[g] <= wdata;
            end
        end
        assign flat[g*XLEN +: XLEN] = regs[g];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (hit && (32'(idx) == i)) rdata = regs[i];
        end
    end
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          NUM_REGS  = 4,
    parameter logic [11:0] BASE_ADDR = 12'h7C0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] src_value,
    input  logic [4:0]      op_field,
    input  logic [4:0]      dst_index,
    output logic [XLEN-1:0] dst_value,
    output logic            dst_write
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    ctl_t                     ctl;
    logic                     hit;
    logic [11:0]              offset;
    logic [IDX_W-1:0]         idx;
    logic [XLEN-1:0]          cur_val;
    logic [XLEN-1:0]          nxt_val;
    logic [NUM_REGS*XLEN-1:0] bank_q;

    assign hit    = addr_hit(csr_addr, BASE_ADDR, NUM_REGS);
    assign offset = csr_addr - BASE_ADDR;
    assign idx    = offset[IDX_W-1:0];

    csr_rmw_decode u_dec (
        .valid (op_valid),
        .code  (op_code),
        .field (op_field),
        .dst   (dst_index),
        .ctl   (ctl)
    );

    csr_rmw_bank #(.XLEN(XLEN), .NUM_REGS(NUM_REGS)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .hit   (hit),
        .idx   (idx),
        .wr    (ctl.wr_en),
        .wdata (nxt_val),
        .rdata (cur_val),
        .flat  (bank_q)
    );

    csr_rmw_merge #(.XLEN(XLEN)) u_mrg (
        .ctl     (ctl),
        .old_val (cur_val),
        .src_val (src_value),
        .imm     (op_field),
        .new_val (nxt_val)
    );

    assign dst_write = ctl.rd_en;
    assign dst_value = ctl.rd_en ? cur_val : '0;
endmodule

// File: rtl/csr_rmw_checker.sv
module csr_rmw_checker #(
    parameter int          XLEN      = 32,
    parameter int          NUM_REGS  = 4,
    parameter logic [11:0] BASE_ADDR = 12'h7C0
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     op_valid,
    input logic [2:0]               op_code,
    input logic [11:0]              csr_addr,
    input logic [4:0]               op_field,
    input logic [4:0]               dst_index,
    input logic [XLEN-1:0]          dst_value,
    input logic                     dst_write,
    input logic [NUM_REGS*XLEN-1:0] bank_q
);
    logic        in_bank;
    logic [11:0] rel;
    logic [XLEN-1:0] stored;

    assign in_bank = (csr_addr >= BASE_ADDR) && (32'(12'(csr_addr - BASE_ADDR)) < NUM_REGS);
    assign rel     = csr_addr - BASE_ADDR;

    always_comb begin
        stored = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (in_bank && (32'(rel) == i)) stored = bank_q[i*XLEN +: XLEN];
        end
    end

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !dst_write);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(bank_q));

    p_swap_x0_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 3'b001 || op_code == 3'b101) && dst_index == 5'd0)
        |-> (!dst_write && dst_value == '0));

    p_masked_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 3'b010 || op_code == 3'b011) && op_field == 5'd0)
        |=> $stable(bank_q));

    p_masked_read_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 3'b010 || op_code == 3'b011)) |-> dst_write);

    p_imm_zero_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code == 3'b110 || op_code == 3'b111) && op_field == 5'd0)
        |=> $stable(bank_q));

    p_old_value_r8: assert property (@(posedge clk) disable iff (rst)
        dst_write |-> dst_value == stored);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (dst_write && !in_bank) |-> dst_value == '0);

    p_unmapped_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !in_bank) |=> $stable(bank_q));
endmodule

bind csr_rmw_unit csr_rmw_checker #(
    .XLEN(XLEN), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .csr_addr  (csr_addr),
    .op_field  (op_field),
    .dst_index (dst_index),
    .dst_value (dst_value),
    .dst_write (dst_write),
    .bank_q    (bank_q)
);

// File: tb/sim_csr_rmw_unit.sv
module sim_csr_rmw_unit;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            op_valid = 1'b0;
    logic [2:0]      op_code = 3'b000;
    logic [11:0]     csr_addr = 12'h000;
    logic [XLEN-1:0] src_value = '0;
    logic [4:0]      op_field = '0;
    logic [4:0]      dst_index = '0;
    logic [XLEN-1:0] dst_value;
    logic            dst_write;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    csr_rmw_unit #(.XLEN(XLEN), .NUM_REGS(4), .BASE_ADDR(12'h7C0)) u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .csr_addr(csr_addr), .src_value(src_value), .op_field(op_field),
        .dst_index(dst_index), .dst_value(dst_value), .dst_write(dst_write)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [11:0] addr;
        logic [31:0] src;
        logic [4:0]  fld;
        logic [4:0]  rd;
        logic [31:0] exp_v;
        logic        exp_w;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  3'b001, 12'h7C0, 32'hDEADBEEF, 5'd1,  5'd1, 32'h00000000, 1'b1}, // R2
        '{4'd3,  3'b001, 12'h7C0, 32'h12345678, 5'd1,  5'd0, 32'h00000000, 1'b0}, // R3
        '{4'd5,  3'b010, 12'h7C0, 32'hF0000000, 5'd3,  5'd2, 32'h12345678, 1'b1}, // R5 set
        '{4'd5,  3'b011, 12'h7C0, 32'h00000078, 5'd4,  5'd2, 32'hF2345678, 1'b1}, // R5 clear
        '{4'd6,  3'b010, 12'h7C0, 32'hFFFFFFFF, 5'd0,  5'd3, 32'hF2345600, 1'b1}, // R6
        '{4'd6,  3'b011, 12'h7C0, 32'hFFFFFFFF, 5'd0,  5'd0, 32'hF2345600, 1'b1}, // R6
        '{4'd8,  3'b001, 12'h7C0, 32'h00000000, 5'd5,  5'd1, 32'hF2345600, 1'b1}, // R8
        '{4'd4,  3'b101, 12'h7C1, 32'hFFFFFFFF, 5'h1F, 5'd4, 32'h00000000, 1'b1}, // R4
        '{4'd7,  3'b110, 12'h7C1, 32'hFFFFFFFF, 5'd0,  5'd5, 32'h0000001F, 1'b1}, // R4 R7
        '{4'd7,  3'b111, 12'h7C1, 32'hFFFFFFFF, 5'h05, 5'd5, 32'h0000001F, 1'b1}, // R7
        '{4'd7,  3'b110, 12'h7C1, 32'h00000000, 5'h01, 5'd6, 32'h0000001A, 1'b1}, // R7
        '{4'd3,  3'b101, 12'h7C1, 32'hFFFFFFFF, 5'd0,  5'd0, 32'h00000000, 1'b0}, // R3
        '{4'd3,  3'b010, 12'h7C1, 32'h00000000, 5'd7,  5'd1, 32'h00000000, 1'b1}, // R3
        '{4'd11, 3'b001, 12'h7C3, 32'hA5A5A5A5, 5'd1,  5'd1, 32'h00000000, 1'b1}, // R11
        '{4'd9,  3'b001, 12'h7C4, 32'h11111111, 5'd1,  5'd1, 32'h00000000, 1'b1}, // R9
        '{4'd9,  3'b010, 12'h7C4, 32'hFFFFFFFF, 5'd1,  5'd1, 32'h00000000, 1'b1}, // R9
        '{4'd9,  3'b001, 12'h7BF, 32'h00000022, 5'd1,  5'd1, 32'h00000000, 1'b1}, // R9
        '{4'd11, 3'b010, 12'h7C3, 32'h00000000, 5'd0,  5'd1, 32'hA5A5A5A5, 1'b1}, // R11
        '{4'd10, 3'b000, 12'h7C3, 32'h00000000, 5'd1,  5'd1, 32'h00000000, 1'b0}, // R10
        '{4'd10, 3'b100, 12'h7C3, 32'h00000000, 5'd1,  5'd1, 32'h00000000, 1'b0}, // R10
        '{4'd10, 3'b010, 12'h7C3, 32'h00000000, 5'd0,  5'd1, 32'hA5A5A5A5, 1'b1}, // R10
        '{4'd3,  3'b001, 12'h7C2, 32'hCAFEF00D, 5'd1,  5'd0, 32'h00000000, 1'b0}, // R3
        '{4'd5,  3'b011, 12'h7C2, 32'h0000F00D, 5'd9,  5'd7, 32'hCAFEF00D, 1'b1}, // R5
        '{4'd5,  3'b110, 12'h7C2, 32'h00000000, 5'd0,  5'd7, 32'hCAFE0000, 1'b1}  // R5
    };

    task automatic check(input int req, input logic [31:0] exp_v, input logic exp_w);
        total++;
        if (dst_value !== exp_v || dst_write !== exp_w) begin
            bad++;
            $display("FAIL R%0d: value=%h write=%b expected value=%h write=%b",
                     req, dst_value, dst_write, exp_v, exp_w);
        end
    endtask

    task automatic apply(input logic v, input logic [2:0] op, input logic [11:0] a,
                         input logic [31:0] s, input logic [4:0] f, input logic [4:0] d);
        @(negedge clk);
        op_valid = v; op_code = op; csr_addr = a; src_value = s; op_field = f; dst_index = d;
        #2;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state after reset, read through immediate set with zero mask
        for (int k = 0; k < 4; k++) begin
            apply(1'b1, 3'b110, 12'h7C0 + 12'(k), 32'hFFFFFFFF, 5'd0, 5'd1);
            check(1, 32'h0, 1'b1);
        end
        for (int i = 0; i < NV; i++) begin
            apply(1'b1, TBL[i].op, TBL[i].addr, TBL[i].src, TBL[i].fld, TBL[i].rd);
            check(int'(TBL[i].req), TBL[i].exp_v, TBL[i].exp_w);
        end
        // R10: op_valid low blocks write and read
        apply(1'b0, 3'b001, 12'h7C3, 32'h00000000, 5'd1, 5'd1);
        check(10, 32'h0, 1'b0);
        apply(1'b1, 3'b010, 12'h7C3, 32'h0, 5'd0, 5'd1);
        check(10, 32'hA5A5A5A5, 1'b1);
        // R8: combinational read follows address within one cycle
        apply(1'b1, 3'b010, 12'h7C0, 32'h0, 5'd0, 5'd1);
        check(8, 32'h0, 1'b1);
        csr_addr = 12'h7C2;
        #1;
        check(8, 32'hCAFE0000, 1'b1);
        // R1: reset mid-run clears all registers
        apply(1'b0, 3'b000, 12'h000, 32'h0, 5'd0, 5'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            apply(1'b1, 3'b011, 12'h7C0 + 12'(k), 32'h0, 5'd0, 5'd2);
            check(1, 32'h0, 1'b1);
        end
        apply(1'b0, 3'b000, 12'h000, 32'h0, 5'd0, 5'd0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule